// File: doc/BRIEF.md
# Return-Address Stack with Privileged Save/Restore

This block is an on-chip stack that keeps only subroutine return addresses, each paired with a tag word. It is separate from any data stack or main memory. The fetch path pushes an entry on a call and pops one on a return. The current top entry is held in a register, so a return sees its address and tag in the same cycle that it asks for the pop. Only call, return, unwind and privileged accesses can move the stack pointer.

An unwind request drops several entries in one cycle, for non-local returns and exception cleanup. A privileged port reads and writes any entry by index, and reads and writes the depth. System software uses it to copy the whole stack out to memory and back in on a task switch. The store behaves as a flat array of CAP slots, and slots above the current depth keep their contents. A restore can therefore write the entries first and set the depth last.

If a request would overflow or underflow the stack, the block raises a one-cycle fault flag and changes nothing. Software can then spill or refill the stack and retry.

Top module: `return_stack`

## Requirements
- R1: The stack holds up to CAP entries (default 1023). `depth_o` gives the entry count. A push stores `{push_addr_i, push_tag_i}` as the new top and adds one to the depth. `top_valid_o` is high exactly when the depth is nonzero.
- R2: Entries come back in last-in first-out order. While a return request is present, `top_addr_o` and `top_tag_o` already show the entry being popped. After the clock edge, the depth is one lower and the entry beneath becomes the top. Depth never changes in a cycle with no request.
- R3: A push alone at depth CAP pulses `ovf_o` high for the following cycle. Depth and contents stay unchanged.
- R4: A return alone at depth zero pulses `unf_o` high for the following cycle. Depth stays zero.
- R5: A push and a return in the same cycle replace the top entry with the pushed one and keep the depth. At depth zero this combination is an underflow instead, and nothing changes.
- R6: `unwind_i` removes `unwind_cnt_i` entries in one cycle. A count of zero has no effect. A count above the depth pulses `unf_o` and changes nothing. An unwind takes precedence over a push or return in the same cycle, and those requests are dropped.
- R7: A privileged read (`priv_en_i`=1, `priv_we_i`=0) updates `priv_rdata_*` one cycle later. With `priv_ptr_i`=1 the result is the depth, zero-extended in the address field, with a zero tag. With `priv_ptr_i`=0 the result is the entry at `priv_idx_i`, where index 0 is the oldest entry. An index of CAP or more reads as zero.
- R8: A privileged entry write stores `{priv_wdata_addr_i, priv_wdata_tag_i}` at `priv_idx_i`, including slots at or above the depth. Writing the index depth-1 changes the visible top at once. An index of CAP or more is ignored.
- R9: A privileged pointer write sets the depth to `priv_wdata_addr_i`, and entry depth-1 becomes the top. A value above CAP pulses `ovf_o` and leaves the depth unchanged.
- R10: The privileged port has priority. Any push, return or unwind in the same cycle is dropped, and `conflict_o` pulses high for the following cycle.
- R11: Reset (`rst_n` low, asynchronous, released through two synchronising flops) clears the depth, all three flags and the privileged read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Call: push a return entry |
| push_addr_i | input | AW | Return address to push |
| push_tag_i | input | TW | Tag word stored with the address |
| ret_i | input | 1 | Return: pop the top entry |
| unwind_i | input | 1 | Drop several entries at once |
| unwind_cnt_i | input | PW | Number of entries to drop |
| priv_en_i | input | 1 | Privileged access request |
| priv_we_i | input | 1 | Privileged access is a write |
| priv_ptr_i | input | 1 | Access targets the depth instead of an entry |
| priv_idx_i | input | PW | Entry index, 0 = oldest |
| priv_wdata_addr_i | input | AW | Write data: address, or the new depth |
| priv_wdata_tag_i | input | TW | Write data: tag |
| top_addr_o | output | AW | Address of the current top entry |
| top_tag_o | output | TW | Tag of the current top entry |
| top_valid_o | output | 1 | Stack is not empty |
| depth_o | output | PW | Number of entries held |
| ovf_o | output | 1 | Overflow fault pulse |
| unf_o | output | 1 | Underflow fault pulse |
| conflict_o | output | 1 | Fetch request dropped in favour of the privileged port |
| priv_rdata_addr_o | output | AW | Privileged read result: address or depth |
| priv_rdata_tag_o | output | TW | Privileged read result: tag |

## Verification
The hazard here is the cached top register drifting away from the array slot it stands for. Such a fault shows up no earlier than the next return, unwind or pointer rewrite that exposes the slot beneath. The bench therefore pops into long-buried slots, rewrites the depth above the old top, and reads back the slot the old top was spilled into. A fault in the depth counter shows at `depth_o` and `top_valid_o` on the cycle after the faulty request. A wrong guard on overflow or underflow shows as a missing one-cycle flag together with a moved depth.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  // source selected for the cached top entry when it loads
  typedef enum logic [1:0] {
    TS_PUSH = 2'd0,
    TS_MEM  = 2'd1,
    TS_PRIV = 2'd2
  } top_src_e;

  // source of an array write: spill of the old top, or privileged data
  typedef enum logic {
    WS_SPILL = 1'b0,
    WS_PRIV  = 1'b1
  } wsrc_e;

  // what a privileged read returns
  typedef enum logic [1:0] {
    RS_ZERO = 2'd0,
    RS_PTR  = 2'd1,
    RS_TOP  = 2'd2,
    RS_MEM  = 2'd3
  } rsel_e;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CAP = 1023,
  localparam int PW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          ret_i,
  input  logic          unwind_i,
  input  logic [PW-1:0] unwind_cnt_i,
  input  logic          priv_en_i,
  input  logic          priv_we_i,
  input  logic          priv_ptr_i,
  input  logic [PW-1:0] priv_idx_i,
  input  logic [AW-1:0] priv_wval_i,
  output logic [PW-1:0] depth_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          conflict_o,
  output logic          mem_we_o,
  output logic [PW-1:0] mem_widx_o,
  output wsrc_e         mem_wsrc_o,
  output logic [PW-1:0] ridx_o,
  output logic          top_ld_o,
  output top_src_e      top_src_o,
  output logic          prd_ld_o,
  output rsel_e         prd_sel_o
);
  localparam logic [PW-1:0] CAP_P = PW'(CAP);
  localparam logic [AW-1:0] CAP_A = AW'(CAP);
  localparam logic [PW-1:0] ONE   = PW'(1);

  logic [PW-1:0] depth_q, depth_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, cfl_q, cfl_d;
  logic          has_top, idx_ok, ptr_ok;
  logic [PW-1:0] top_idx, ptr_v;

  assign has_top = (depth_q != '0);
  assign top_idx = depth_q - ONE;
  assign idx_ok  = (priv_idx_i < CAP_P);
  assign ptr_ok  = (priv_wval_i <= CAP_A);
  assign ptr_v   = priv_wval_i[PW-1:0];

  always_comb begin
    depth_d    = depth_q;
    ovf_d      = 1'b0;
    unf_d      = 1'b0;
    cfl_d      = 1'b0;
    mem_we_o   = 1'b0;
    mem_widx_o = top_idx;
    mem_wsrc_o = WS_SPILL;
    ridx_o     = '0;
    top_ld_o   = 1'b0;
    top_src_o  = TS_PUSH;
    prd_ld_o   = 1'b0;
    prd_sel_o  = RS_ZERO;
    if (priv_en_i) begin
      cfl_d = push_i | ret_i | unwind_i;
      if (priv_we_i && priv_ptr_i) begin
        if (!ptr_ok) begin
          ovf_d = 1'b1;
        end else begin
          mem_we_o = has_top;          // flatten the cached top into its slot
          if (ptr_v != '0 && ptr_v != depth_q) begin
            top_ld_o  = 1'b1;
            top_src_o = TS_MEM;
            ridx_o    = ptr_v - ONE;
          end
          depth_d = ptr_v;
        end
      end else if (priv_we_i) begin
        if (idx_ok) begin
          if (has_top && priv_idx_i == top_idx) begin
            top_ld_o  = 1'b1;
            top_src_o = TS_PRIV;
          end else begin
            mem_we_o   = 1'b1;
            mem_widx_o = priv_idx_i;
            mem_wsrc_o = WS_PRIV;
          end
        end
      end else begin
        prd_ld_o = 1'b1;
        if (priv_ptr_i)                         prd_sel_o = RS_PTR;
        else if (!idx_ok)                       prd_sel_o = RS_ZERO;
        else if (has_top && priv_idx_i == top_idx) prd_sel_o = RS_TOP;
        else begin
          prd_sel_o = RS_MEM;
          ridx_o    = priv_idx_i;
        end
      end
    end else if (unwind_i) begin
      if (unwind_cnt_i > depth_q) begin
        unf_d = 1'b1;
      end else if (unwind_cnt_i != '0) begin
        depth_d = depth_q - unwind_cnt_i;
        if (unwind_cnt_i < depth_q) begin
          top_ld_o  = 1'b1;
          top_src_o = TS_MEM;
          ridx_o    = depth_q - unwind_cnt_i - ONE;
        end
      end
    end else if (push_i && ret_i) begin
      if (!has_top) unf_d = 1'b1;
      else top_ld_o = 1'b1;
    end else if (push_i) begin
      if (depth_q == CAP_P) begin
        ovf_d = 1'b1;
      end else begin
        mem_we_o = has_top;
        top_ld_o = 1'b1;
        depth_d  = depth_q + ONE;
      end
    end else if (ret_i) begin
      if (!has_top) begin
        unf_d = 1'b1;
      end else begin
        depth_d = top_idx;
        if (depth_q > ONE) begin
          top_ld_o  = 1'b1;
          top_src_o = TS_MEM;
          ridx_o    = depth_q - PW'(2);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      cfl_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      cfl_q   <= cfl_d;
    end
  end

  assign depth_o    = depth_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
  assign conflict_o = cfl_q;

  logic fetch_only;
  assign fetch_only = !priv_en_i && !unwind_i;

  p_depth_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CAP_P);
  p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_only && push_i && !ret_i && depth_q < CAP_P |=> depth_q == $past(depth_q) + ONE);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_only && !push_i && !ret_i |=> $stable(depth_q));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_only && push_i && !ret_i && depth_q == CAP_P |=> ovf_o && $stable(depth_q));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_only && ret_i && !push_i && depth_q == '0 |=> unf_o && depth_q == '0);
  p_replace_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_only && push_i && ret_i |=> $stable(depth_q));
  p_unwind_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_en_i && unwind_i && unwind_cnt_i > depth_q |=> unf_o && $stable(depth_q));
  p_priv_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    priv_en_i && (push_i || ret_i || unwind_i) |=> conflict_o);
  p_priv_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_en_i && !priv_we_i |=> $stable(depth_q));
endmodule

// File: rtl/rstk_store.sv
module rstk_store
  import rstk_pkg::*;
#(
  parameter int EW  = 48,
  parameter int CAP = 1023,
  localparam int PW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_we_i,
  input  logic [PW-1:0] mem_widx_i,
  input  wsrc_e         mem_wsrc_i,
  input  logic [PW-1:0] ridx_i,
  input  logic          top_ld_i,
  input  top_src_e      top_src_i,
  input  logic [EW-1:0] push_entry_i,
  input  logic [EW-1:0] priv_entry_i,
  output logic [EW-1:0] top_o,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [CAP];
  logic [EW-1:0] top_q, top_d, wdata;

  assign wdata   = (mem_wsrc_i == WS_PRIV) ? priv_entry_i : top_q;
  assign rdata_o = mem_q[ridx_i];

  always_ff @(posedge clk) begin
    if (mem_we_i) mem_q[mem_widx_i] <= wdata;
  end

  always_comb begin
    unique case (top_src_i)
      TS_MEM:  top_d = rdata_o;
      TS_PRIV: top_d = priv_entry_i;
      default: top_d = push_entry_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        top_q <= '0;
    else if (top_ld_i) top_q <= top_d;
  end

  assign top_o = top_q;

  p_spill_keeps_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_i && mem_wsrc_i == WS_SPILL && !top_ld_i |=> $stable(top_q));
endmodule

// File: rtl/return_stack.sv
module return_stack
  import rstk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int TW  = 16,
  parameter int CAP = 1023,
  localparam int PW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [TW-1:0] push_tag_i,
  input  logic          ret_i,
  input  logic          unwind_i,
  input  logic [PW-1:0] unwind_cnt_i,
  input  logic          priv_en_i,
  input  logic          priv_we_i,
  input  logic          priv_ptr_i,
  input  logic [PW-1:0] priv_idx_i,
  input  logic [AW-1:0] priv_wdata_addr_i,
  input  logic [TW-1:0] priv_wdata_tag_i,
  output logic [AW-1:0] top_addr_o,
  output logic [TW-1:0] top_tag_o,
  output logic          top_valid_o,
  output logic [PW-1:0] depth_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          conflict_o,
  output logic [AW-1:0] priv_rdata_addr_o,
  output logic [TW-1:0] priv_rdata_tag_o
);
  localparam int EW = AW + TW;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic          mem_we, top_ld, prd_ld;
  logic [PW-1:0] mem_widx, ridx;
  wsrc_e         mem_wsrc;
  top_src_e      top_src;
  rsel_e         prd_sel;
  logic [EW-1:0] top_entry, mem_rdata, prd_d, prd_q;

  rstk_ctrl #(.AW(AW), .CAP(CAP)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sn),
    .push_i       (push_i),
    .ret_i        (ret_i),
    .unwind_i     (unwind_i),
    .unwind_cnt_i (unwind_cnt_i),
    .priv_en_i    (priv_en_i),
    .priv_we_i    (priv_we_i),
    .priv_ptr_i   (priv_ptr_i),
    .priv_idx_i   (priv_idx_i),
    .priv_wval_i  (priv_wdata_addr_i),
    .depth_o      (depth_o),
    .ovf_o        (ovf_o),
    .unf_o        (unf_o),
    .conflict_o   (conflict_o),
    .mem_we_o     (mem_we),
    .mem_widx_o   (mem_widx),
    .mem_wsrc_o   (mem_wsrc),
    .ridx_o       (ridx),
    .top_ld_o     (top_ld),
    .top_src_o    (top_src),
    .prd_ld_o     (prd_ld),
    .prd_sel_o    (prd_sel)
  );

  rstk_store #(.EW(EW), .CAP(CAP)) u_store (
    .clk          (clk),
    .rst_n        (rst_sn),
    .mem_we_i     (mem_we),
    .mem_widx_i   (mem_widx),
    .mem_wsrc_i   (mem_wsrc),
    .ridx_i       (ridx),
    .top_ld_i     (top_ld),
    .top_src_i    (top_src),
    .push_entry_i ({push_addr_i, push_tag_i}),
    .priv_entry_i ({priv_wdata_addr_i, priv_wdata_tag_i}),
    .top_o        (top_entry),
    .rdata_o      (mem_rdata)
  );

  always_comb begin
    unique case (prd_sel)
      RS_PTR:  prd_d = {AW'(depth_o), TW'(0)};
      RS_TOP:  prd_d = top_entry;
      RS_MEM:  prd_d = mem_rdata;
      default: prd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     prd_q <= '0;
    else if (prd_ld) prd_q <= prd_d;
  end

  assign top_addr_o        = top_entry[EW-1:TW];
  assign top_tag_o         = top_entry[TW-1:0];
  assign top_valid_o       = (depth_o != '0);
  assign priv_rdata_addr_o = prd_q[EW-1:TW];
  assign priv_rdata_tag_o  = prd_q[TW-1:0];

  p_push_shows_top_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    push_i && !priv_en_i && !unwind_i &&
    (ret_i ? depth_o != '0 : depth_o < PW'(CAP))
    |=> top_addr_o == $past(push_addr_i) && top_tag_o == $past(push_tag_i));
  p_flags_after_reset_r11: assert property (@(posedge clk)
    !rst_sn |-> !ovf_o && !unf_o && !conflict_o && depth_o == '0);
endmodule

// File: tb/return_stack_test.sv
`timescale 1ns/1ps
module return_stack_test;
  localparam int AW  = 32;
  localparam int TW  = 16;
  localparam int CAP = 1023;
  localparam int PW  = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i, ret_i, unwind_i, priv_en_i, priv_we_i, priv_ptr_i;
  logic [AW-1:0] push_addr_i, priv_wdata_addr_i;
  logic [TW-1:0] push_tag_i, priv_wdata_tag_i;
  logic [PW-1:0] unwind_cnt_i, priv_idx_i;
  logic [AW-1:0] top_addr_o, priv_rdata_addr_o;
  logic [TW-1:0] top_tag_o, priv_rdata_tag_o;
  logic          top_valid_o, ovf_o, unf_o, conflict_o;
  logic [PW-1:0] depth_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  return_stack #(.AW(AW), .TW(TW), .CAP(CAP)) uut (.*);

  function automatic logic [TW-1:0] tag_of(logic [AW-1:0] a);
    return a[TW-1:0] ^ 16'h5A5A;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    push_i = 0; ret_i = 0; unwind_i = 0; priv_en_i = 0; priv_we_i = 0;
    priv_ptr_i = 0; push_addr_i = '0; push_tag_i = '0; unwind_cnt_i = '0;
    priv_idx_i = '0; priv_wdata_addr_i = '0; priv_wdata_tag_i = '0;
  endtask

  // inputs set at posedge+1; this captures them and returns at posedge+1
  task automatic cyc();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic do_push(logic [AW-1:0] a);
    push_i = 1; push_addr_i = a; push_tag_i = tag_of(a);
    cyc();
  endtask

  task automatic priv_rd(logic ptr, logic [PW-1:0] idx);
    priv_en_i = 1; priv_ptr_i = ptr; priv_idx_i = idx;
    cyc();
  endtask

  task automatic priv_wr(logic ptr, logic [PW-1:0] idx, logic [AW-1:0] a, logic [TW-1:0] t);
    priv_en_i = 1; priv_we_i = 1; priv_ptr_i = ptr; priv_idx_i = idx;
    priv_wdata_addr_i = a; priv_wdata_tag_i = t;
    cyc();
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  typedef struct packed {
    logic          push;
    logic          ret;
    logic [31:0]   addr;
    logic [9:0]    dep;
    logic          vld;
    logic [31:0]   top;
    logic          unf;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 32'h0000_A001, 10'd1, 1'b1, 32'h0000_A001, 1'b0},
    '{1'b1, 1'b0, 32'h0000_A002, 10'd2, 1'b1, 32'h0000_A002, 1'b0},
    '{1'b1, 1'b0, 32'h0000_A003, 10'd3, 1'b1, 32'h0000_A003, 1'b0},
    '{1'b0, 1'b1, 32'h0,         10'd2, 1'b1, 32'h0000_A002, 1'b0},
    '{1'b1, 1'b1, 32'h0000_B001, 10'd2, 1'b1, 32'h0000_B001, 1'b0},
    '{1'b0, 1'b1, 32'h0,         10'd1, 1'b1, 32'h0000_A001, 1'b0},
    '{1'b1, 1'b0, 32'h0000_C001, 10'd2, 1'b1, 32'h0000_C001, 1'b0},
    '{1'b0, 1'b1, 32'h0,         10'd1, 1'b1, 32'h0000_A001, 1'b0},
    '{1'b0, 1'b1, 32'h0,         10'd0, 1'b0, 32'h0,         1'b0},
    '{1'b1, 1'b1, 32'h0000_D001, 10'd0, 1'b0, 32'h0,         1'b1},
    '{1'b0, 1'b1, 32'h0,         10'd0, 1'b0, 32'h0,         1'b1}
  };

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 depth", 64'(depth_o), 64'd0);
    chk("R11 valid", 64'(top_valid_o), 64'd0);
    chk("R11 flags", 64'({ovf_o, unf_o, conflict_o}), 64'd0);
    chk("R11 rdata", 64'(priv_rdata_addr_o), 64'd0);
    rst_n = 1;
    repeat (4) cyc();

    // R1 R2 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      push_i = VEC[i].push; ret_i = VEC[i].ret;
      push_addr_i = VEC[i].addr; push_tag_i = tag_of(VEC[i].addr);
      cyc();
      chk("R1/R2 table depth", 64'(depth_o), 64'(VEC[i].dep));
      chk("R1 table valid", 64'(top_valid_o), 64'(VEC[i].vld));
      chk("R4/R5 table underflow", 64'(unf_o), 64'(VEC[i].unf));
      if (VEC[i].vld) begin
        chk("R2 table top", 64'(top_addr_o), 64'(VEC[i].top));
        chk("R2 table tag", 64'(top_tag_o), 64'(tag_of(VEC[i].top)));
      end
    end
    cyc();

    // R1 R3: fill to capacity, then overflow
    for (int i = 0; i < CAP; i++) do_push(32'h1000 + i);
    chk("R1 full depth", 64'(depth_o), 64'(CAP));
    do_push(32'hBEEF);
    chk("R3 ovf pulse", 64'(ovf_o), 64'd1);
    chk("R3 depth kept", 64'(depth_o), 64'(CAP));
    chk("R3 top kept", 64'(top_addr_o), 64'h13FE);
    cyc();
    chk("R3 ovf one cycle", 64'(ovf_o), 64'd0);

    // R2: pop shows the top combinationally before the edge
    ret_i = 1;
    #0.5;
    chk("R2 same-cycle return addr", 64'(top_addr_o), 64'h13FE);
    chk("R2 same-cycle return tag", 64'(top_tag_o), 64'(tag_of(32'h13FE)));
    cyc();
    chk("R2 next top", 64'(top_addr_o), 64'h13FD);
    do_push(32'h13FE);

    // R6: unwind
    unwind_i = 1; unwind_cnt_i = 10'd1000; cyc();
    chk("R6 unwind depth", 64'(depth_o), 64'd23);
    chk("R6 unwind top", 64'(top_addr_o), 64'h1016);
    chk("R6 unwind tag", 64'(top_tag_o), 64'(tag_of(32'h1016)));
    unwind_i = 1; unwind_cnt_i = 10'd24; cyc();
    chk("R6 unwind too far", 64'(unf_o), 64'd1);
    chk("R6 unwind too far depth", 64'(depth_o), 64'd23);
    unwind_i = 1; unwind_cnt_i = 10'd0; cyc();
    chk("R6 unwind zero", 64'({depth_o, unf_o}), 64'({10'd23, 1'b0}));
    unwind_i = 1; unwind_cnt_i = 10'd3; push_i = 1; push_addr_i = 32'hBEEF; cyc();
    chk("R6 unwind beats push depth", 64'(depth_o), 64'd20);
    chk("R6 unwind beats push top", 64'(top_addr_o), 64'h1013);

    // R7: privileged reads
    priv_rd(1'b0, 10'd5);
    chk("R7 read entry", 64'(priv_rdata_addr_o), 64'h1005);
    chk("R7 read tag", 64'(priv_rdata_tag_o), 64'(tag_of(32'h1005)));
    priv_rd(1'b1, 10'd0);
    chk("R7 read ptr", 64'({priv_rdata_addr_o, priv_rdata_tag_o}), 64'({32'd20, 16'd0}));
    priv_rd(1'b0, 10'd19);
    chk("R7 read top slot", 64'(priv_rdata_addr_o), 64'h1013);
    priv_rd(1'b0, 10'd1023);
    chk("R7 read out of range", 64'(priv_rdata_addr_o), 64'd0);

    // R8 R9: write above depth, then move the pointer over it
    priv_wr(1'b0, 10'd100, 32'hDEAD, 16'h0DEA);
    priv_rd(1'b0, 10'd100);
    chk("R8 write above depth", 64'(priv_rdata_addr_o), 64'hDEAD);
    chk("R8 depth untouched", 64'(depth_o), 64'd20);
    priv_wr(1'b1, 10'd0, 32'd101, 16'd0);
    chk("R9 ptr write depth", 64'(depth_o), 64'd101);
    chk("R9 ptr write top", 64'({top_addr_o, top_tag_o}), 64'({32'hDEAD, 16'h0DEA}));
    priv_rd(1'b0, 10'd19);
    chk("R9 old top spilled", 64'(priv_rdata_addr_o), 64'h1013);
    ret_i = 1; cyc();
    chk("R9 retained slot pops", 64'(top_addr_o), 64'h1063);
    chk("R9 depth after pop", 64'(depth_o), 64'd100);
    priv_wr(1'b1, 10'd0, 32'd1024, 16'd0);
    chk("R9 ptr too big ovf", 64'(ovf_o), 64'd1);
    chk("R9 ptr too big depth", 64'(depth_o), 64'd100);

    // R8: out-of-range write ignored; top-slot write visible at once
    priv_wr(1'b0, 10'd1023, 32'h7777, 16'h7777);
    priv_rd(1'b0, 10'd1023);
    chk("R8 ignored write", 64'(priv_rdata_addr_o), 64'd0);
    chk("R8 ignored write top", 64'({depth_o, top_addr_o}), 64'({10'd100, 32'h1063}));
    priv_wr(1'b0, 10'd99, 32'h4444, 16'h4444);
    chk("R8 top slot write", 64'(top_addr_o), 64'h4444);

    // R10: priority of the privileged port
    push_i = 1; ret_i = 1; push_addr_i = 32'h9999;
    priv_rd(1'b1, 10'd0);
    chk("R10 conflict", 64'(conflict_o), 64'd1);
    chk("R10 depth kept", 64'(depth_o), 64'd100);
    chk("R10 top kept", 64'(top_addr_o), 64'h4444);
    chk("R10 read served", 64'(priv_rdata_addr_o), 64'd100);
    cyc();
    chk("R10 conflict one cycle", 64'(conflict_o), 64'd0);

    // R11: reset in mid-run
    rst_n = 0;
    #1;
    chk("R11 async clear", 64'(depth_o), 64'd0);
    repeat (2) cyc();
    rst_n = 1;
    repeat (4) cyc();
    chk("R11 after release", 64'({top_valid_o, priv_rdata_addr_o}), 64'd0);

    finish_run();
  end
endmodule